// File: doc/BRIEF.md
# External Bus Access Stretch Controller

This block turns a single internal access request into one timed access on an external asynchronous memory or peripheral bus. It drives chip select, a write strobe, the address and the write data. It then holds the access for a programmed number of stretch cycles before it ends the access. Read data is captured in the final cycle of the access. A one-cycle done pulse follows, with the read data, and the same pulse also closes a write.

A 3-bit stretch setting gives between one and eight stretch cycles. A wait-mode enable lets a slow device lengthen the access through an external wait line. The controller brings that line into the clock domain through a two-flop synchronizer. It adds one cycle for every cycle in which the synchronized line is high, starting from the last programmed stretch cycle. In wait mode, the stretch is never shorter than two cycles. A request that arrives during an access stalls until the final cycle of that access. A request accepted in a final cycle starts on the very next cycle, with no idle gap.

Top module: `ext_stretch_ctrl`

## Requirements
- R1: After reset, `bus_cs_n` and `bus_we_n` are 1, `bus_oe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: With wait mode off, an access keeps `bus_cs_n` low for exactly cfg_stretch+2 cycles: one setup cycle plus cfg_stretch+1 stretch cycles, so 2 to 9 cycles in all.
- R3: With wait mode off, `bus_wait` has no effect, and the access length is as in R2 even when `bus_wait` is held high.
- R4: With wait mode on and `bus_wait` low, the stretch is max(cfg_stretch+1, 2) cycles, and the access lasts one cycle more than that.
- R5: With wait mode on, `bus_wait` passes through two flops. Each cycle at or after the last programmed stretch cycle in which the synchronized value is 1 adds a cycle, without limit. If `bus_wait` is high from before the access and its value at the end of access cycle k (cycle 0 is the setup cycle) is first 0, the final cycle is max(stretch of R4, k+2).
- R6: During an access, `bus_addr` and `bus_we_n` hold the accepted values. On a write (`req_write`=1), `bus_we_n` is 0, `bus_oe` is 1 and `bus_dout` carries the write data from the first cycle to the last.
- R7: A read captures `bus_din` at the end of the final access cycle and presents it on `rsp_rdata` while `rsp_done` is high.
- R8: `rsp_done` is high for exactly the one cycle after the final cycle of each access, read or write.
- R9: `req_ready` is 0 in every non-final access cycle and 1 when idle or in the final cycle. A request accepted in a final cycle starts on the next cycle with no idle cycle between the two accesses.
- R10: `cfg_stretch` and `cfg_wait_en` are sampled when a request is accepted. Changes to them during an access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| cfg_stretch | input | SW | Programmed extra stretch (total stretch = value + 1) |
| cfg_wait_en | input | 1 | Enables the external wait line |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_din | input | DW | External read data |
| bus_wait | input | 1 | Asynchronous wait request, active high |

## Verification
An access accepted at a clock edge has its setup cycle right after that edge. `rsp_done` and the read data come one cycle after the final access cycle. A change on `bus_wait` reaches the decision logic two edges later, which is why the expected final cycle is max(stretch, k+2). The bench drives all inputs at falling edges and samples all outputs there. At each falling edge it counts the cycles with chip select low until done is seen. It drops the wait line at the falling edge of the chosen access cycle and compares the count against a function of the latched setting, the wait mode and k.

// File: rtl/ext_stretch_ctrl.sv
module ext_stretch_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] cfg_stretch,
  input  logic          cfg_wait_en,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_cs_n,
  output logic          bus_we_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_wait
);
  localparam int CW = SW + 1;

  logic          busy, we_q, wen_q, wsync1, wsync2;
  logic [SW-1:0] cfg_q;
  logic [CW-1:0] cnt, base;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          at_base, hold, fin, accept;

  assign base    = (wen_q && cfg_q == '0) ? CW'(2) : CW'(cfg_q) + CW'(1);
  assign at_base = (cnt == base);
  assign hold    = wen_q && wsync2;
  assign fin     = busy && at_base && !hold;

  assign req_ready = !busy || fin;
  assign accept    = req_valid && req_ready;

  assign bus_cs_n = !busy;
  assign bus_we_n = !(busy && we_q);
  assign bus_oe   = busy && we_q;
  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync1 <= 1'b0;
      wsync2 <= 1'b0;
    end else begin
      wsync1 <= bus_wait;
      wsync2 <= wsync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cfg_q   <= '0;
      wen_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= '0;
      cfg_q   <= cfg_stretch;
      wen_q   <= cfg_wait_en;
      we_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy && !at_base) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= fin;
      if (fin && !we_q) rsp_rdata <= bus_din;
    end
  end
endmodule

// File: rtl/ext_stretch_ctrl_chk.sv
module ext_stretch_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          cfg_wait_en,
  input logic          ready,
  input logic          done,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe,
  input logic [AW-1:0] addr
);
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ready) |=> (!cs_n && $stable(addr) && $stable(we_n)));

  a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe && !cs_n));

  a_r8_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ready) |=> done);

  a_r8_done_only_then: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && ready) |=> !done);

  a_r2_setup_not_final: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> (!cs_n && !ready));

  a_r4_wait_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && cfg_wait_en) |=> !ready ##1 !ready);

  a_r9_stall_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !cs_n);
endmodule

bind ext_stretch_ctrl ext_stretch_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_wait_en(cfg_wait_en),
  .ready(req_ready), .done(rsp_done), .cs_n(bus_cs_n), .we_n(bus_we_n),
  .oe(bus_oe), .addr(bus_addr)
);

// File: tb/ext_stretch_ctrl_test.sv
module ext_stretch_ctrl_test;
  localparam int AW = 16, DW = 32, SW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, cfg_wait_en = 0, bus_wait = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [SW-1:0] cfg_stretch = '0;
  logic req_ready, rsp_done, bus_cs_n, bus_we_n, bus_oe;
  logic [DW-1:0] rsp_rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;
  assign bus_din = {~bus_addr, bus_addr};

  ext_stretch_ctrl #(.AW(AW), .DW(DW), .SW(SW)) uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int cfg, bit wen, bit wt, int k);
    int b = cfg + 1;
    if (wen && b < 2) b = 2;
    if (wen && wt && k + 2 > b) b = k + 2;
    return b + 1;
  endfunction

  function automatic logic [DW-1:0] rd_val(logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int cfg, input bit wen, input bit wt, input int k, input string tag);
    int n = 0, guard = 0;
    bit ok_hold = 1, got_done = 0;
    if (wt) begin
      bus_wait = 1;
      repeat (3) @(negedge clk);
    end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    cfg_stretch = SW'(cfg); cfg_wait_en = wen;
    @(negedge clk);
    req_valid = 0;
    cfg_stretch = ~SW'(cfg); cfg_wait_en = ~wen;
    while (!got_done && guard < 100) begin
      guard++;
      if (rsp_done) begin
        got_done = 1;
        if (!wr) chk(rsp_rdata == rd_val(a), "R7 read data", rsp_rdata, rd_val(a));
      end else if (!bus_cs_n) begin
        if (bus_addr != a || bus_we_n != !wr || bus_oe != wr || (wr && bus_dout != d)) ok_hold = 0;
        if (n == 0) chk(req_ready == 0, "R9 ready low in setup", req_ready, 0);
        if (wt && n == k) bus_wait = 0;
        n++;
      end
      if (!got_done) @(negedge clk);
    end
    bus_wait = 0;
    chk(n == exp_len(cfg, wen, wt, k), tag, n, exp_len(cfg, wen, wt, k));
    chk(ok_hold, "R6 hold and drive", ok_hold, 1);
    @(negedge clk);
    chk(rsp_done == 0 && bus_cs_n == 1, "R8 single done pulse", rsp_done, 0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk(bus_cs_n == 1 && bus_we_n == 1 && bus_oe == 0 && rsp_done == 0, "R1 reset outputs", bus_cs_n, 1);
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < 8; c++) access(c[0], AW'(16'h100 + c), DW'(32'hA000 + c), c, 0, 0, 0, "R2 length no wait");
    for (int c = 0; c < 8; c++) access(0, AW'(16'h200 + c), '0, c, 0, 1, 12, "R3 wait ignored");
    for (int c = 0; c < 8; c++) access(1, AW'(16'h300 + c), DW'(c), c, 1, 0, 0, "R4 wait mode min stretch");
    for (int k = 0; k < 12; k++) access(0, AW'(16'h400 + k), '0, 0, 1, 1, k, "R5 wait held k cycles");
    access(1, 16'h500, 32'hDEAD, 7, 1, 1, 3, "R5 wait shorter than stretch");
    access(0, 16'h501, '0, 1, 1, 1, 40, "R5 long wait");
    access(0, 16'h502, '0, 5, 0, 0, 0, "R10 config latched");

    for (int i = 0; i < 60; i++) begin
      int c = $urandom_range(0, 7);
      bit wen = 1'($urandom_range(0, 1));
      bit wt = 1'($urandom_range(0, 1));
      int k = $urandom_range(0, 10);
      access(1'($urandom_range(0, 1)), AW'($urandom), DW'($urandom), c, wen, wt, k, "R5 random length");
    end

    begin
      int run = 0, dones = 0, first_rdy = -1, guard = 0;
      logic [AW-1:0] a2 = '0;
      req_valid = 1; req_write = 0; req_addr = 16'h0A0; cfg_stretch = 3'd2; cfg_wait_en = 0;
      @(negedge clk);
      req_addr = 16'h0B0; cfg_stretch = 3'd1;
      while ((!bus_cs_n || run == 0) && guard < 50) begin
        guard++;
        if (rsp_done) dones++;
        if (!bus_cs_n) begin
          if (run == 4) a2 = bus_addr;
          if (req_ready && first_rdy < 0) begin first_rdy = run; end
          run++;
        end
        if (first_rdy >= 0 && req_valid && run > first_rdy + 1) req_valid = 0;
        @(negedge clk);
      end
      if (rsp_done) dones++;
      chk(run == 7, "R9 back to back no gap", run, 7);
      chk(first_rdy == 3, "R9 ready in final cycle", first_rdy, 3);
      chk(a2 == 16'h0B0, "R9 second access address", a2, 16'h0B0);
      chk(dones == 2, "R8 two done pulses", dones, 2);
      req_valid = 0;
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule